// File: doc/BRIEF.md
# Cycle Counter Tap Event Generator

This block runs a free-running cycle counter and derives timed events from it. A low-order bit of the counter, one of two positions picked by a one-bit select, is watched for changes. Each change in either direction is one tick into a small down-counting postscaler. A tick that finds the postscaler at zero fires an event and reloads the postscaler from a preset. That event goes out as a PC-sample pulse when PC sampling is enabled. Otherwise it goes out as a cycle-count pulse, if that event is enabled.

A second path watches one of three high-order counter bits, picked by a two-bit field. It emits a one-cycle synchronization pulse on every change of that bit, for use by a trace packet unit. Software drives every control input as a held register value. The outputs are single-cycle pulses and the live counter value.

All tap positions, the counter width and the postscaler width are parameters. The defaults give a 32-bit counter, low taps at bits 6 and 10, sync taps at bits 24, 26 and 28, and a 4-bit postscaler.

Top module: `cyc_tap_evgen`

## Requirements
- R1: `cyc_count` increments by one on each clock edge at which `cnt_en` is 1, holds its value when `cnt_en` is 0, and wraps from all ones to zero (modulo 2^CNT_W).
- R2: While `rst_n` is 0, `cyc_count` is 0, the postscaler is 0 and `pc_sample_ev`, `cyc_ev` and `sync_pulse` are all 0.
- R3: `lo_tap_sel` = 0 watches counter bit LO_A (default 6) and `lo_tap_sel` = 1 watches bit LO_B (default 10). A change of the watched bit between two consecutive counter values, 0 to 1 or 1 to 0, is one tap tick.
- R4: On a tap tick the postscaler decrements by one if it is nonzero. If it is zero, it fires and reloads from `ps_preset`. After reset, the first tick fires, and from then on one fire occurs every `ps_preset`+1 ticks.
- R5: When the postscaler fires with `pcs_en` = 1, `pc_sample_ev` is 1 in the cycle after the counter first shows the changed tap bit.
- R6: When the postscaler fires with `pcs_en` = 0 and `cyc_ev_en` = 1, `cyc_ev` pulses with the same timing as R5. While `pcs_en` is 1, `cyc_ev` stays 0 whatever `cyc_ev_en` is.
- R7: `sync_sel` encodes the sync source: 2'b00 off (no pulse ever), 2'b01 bit SY_1 (default 24), 2'b10 bit SY_2 (default 26), 2'b11 bit SY_3 (default 28). Each change of the selected bit gives a `sync_pulse` in the cycle after the counter shows it.
- R8: `sync_pulse` is produced only if `cnt_en` was 1 at the clock edge that registers it.
- R9: Each of `pc_sample_ev`, `cyc_ev` and `sync_pulse` is high for one cycle per event and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter enable |
| lo_tap_sel | input | 1 | Low tap select: 0 = bit LO_A, 1 = bit LO_B |
| sync_sel | input | 2 | Sync tap select: 00 off, 01/10/11 = SY_1/SY_2/SY_3 |
| pcs_en | input | 1 | PC-sample event enable, overrides cycle-count event |
| cyc_ev_en | input | 1 | Cycle-count event enable |
| ps_preset | input | PS_W | Postscaler reload value |
| cyc_count | output | CNT_W | Current counter value |
| pc_sample_ev | output | 1 | PC-sample event pulse |
| cyc_ev | output | 1 | Cycle-count event pulse |
| sync_pulse | output | 1 | Synchronization pulse |

## Verification
The bench goes after several corner cases, each with a distinct failure:
- Falling edges of the tap: a design that counts only rising edges would emit half the events.
- The zero state of the postscaler: firing on reaching zero rather than on a tick at zero would shift every event early by one tick. Reloading with the wrong preset would break the one-in-(preset+1) spacing.
- The priority of `pcs_en` over `cyc_ev_en`: a design that missed it would drive both pulses together.
- Sync with `cnt_en` dropped right after a tap change, and `sync_sel` = 00: a missing gate would leak a sync pulse.
- Counter wrap at all ones: a width slip would surface here.

// File: rtl/cyc_tap_pkg.sv
package cyc_tap_pkg;

  // Next postscaler value: decrement on a tick, reload from preset on a tick at zero.
  function automatic logic [31:0] ps_next(input logic [31:0] ps,
                                          input logic [31:0] preset,
                                          input logic        tick);
    if (!tick)         return ps;
    else if (ps == 0)  return preset;
    else               return ps - 32'd1;
  endfunction

  // A tick at zero is a fire.
  function automatic logic ps_fires(input logic [31:0] ps, input logic tick);
    return tick && (ps == 0);
  endfunction

  // Sync path is live only with the counter running and a source chosen.
  function automatic logic sync_live(input logic en, input logic [1:0] sel);
    return en && (sel != 2'b00);
  endfunction

endpackage

// File: rtl/cyc_tap_counter.sv
module cyc_tap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cnt_prev <= '0;
    end else begin
      cnt_prev <= cnt_q;
      if (en) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cyc_tap_edge.sv
module cyc_tap_edge #(
  parameter int               W     = 32,
  parameter int               NUM   = 2,
  parameter int               SEL_W = (NUM > 1) ? $clog2(NUM) : 1,
  parameter logic [NUM*8-1:0] POSV  = '0
) (
  input  logic [W-1:0]     cur,
  input  logic [W-1:0]     prev,
  input  logic [SEL_W-1:0] sel,
  output logic             toggle
);
  logic [NUM-1:0] hit;

  for (genvar g = 0; g < NUM; g++) begin : g_tap
    localparam int P = int'(POSV[g*8 +: 8]);
    assign hit[g] = cur[P] ^ prev[P];
  end

  assign toggle = hit[sel];
endmodule

// File: rtl/cyc_tap_postscaler.sv
module cyc_tap_postscaler
  import cyc_tap_pkg::*;
#(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PS_W-1:0] preset,
  output logic            fire,
  output logic [PS_W-1:0] ps_q
);
  logic [PS_W-1:0] ps_d;

  assign ps_d = PS_W'(ps_next(32'(ps_q), 32'(preset), tick));
  assign fire = ps_fires(32'(ps_q), tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end
endmodule

// File: rtl/cyc_tap_evgen.sv
module cyc_tap_evgen
  import cyc_tap_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PS_W  = 4,
  parameter int LO_A  = 6,
  parameter int LO_B  = 10,
  parameter int SY_1  = 24,
  parameter int SY_2  = 26,
  parameter int SY_3  = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             lo_tap_sel,
  input  logic [1:0]       sync_sel,
  input  logic             pcs_en,
  input  logic             cyc_ev_en,
  input  logic [PS_W-1:0]  ps_preset,
  output logic [CNT_W-1:0] cyc_count,
  output logic             pc_sample_ev,
  output logic             cyc_ev,
  output logic             sync_pulse
);
  localparam logic [15:0] LO_POSV = {8'(LO_B), 8'(LO_A)};
  localparam logic [31:0] SY_POSV = {8'(SY_3), 8'(SY_2), 8'(SY_1), 8'(SY_1)};

  // Named internal events, observed by the checker
  logic [CNT_W-1:0] cnt_prev;
  logic             lo_tick;
  logic             sync_tick;
  logic             ps_fire;
  logic [PS_W-1:0]  ps_val;

  cyc_tap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cnt_en),
    .cnt_q    (cyc_count),
    .cnt_prev (cnt_prev)
  );

  cyc_tap_edge #(.W(CNT_W), .NUM(2), .SEL_W(1), .POSV(LO_POSV)) u_lo_edge (
    .cur    (cyc_count),
    .prev   (cnt_prev),
    .sel    (lo_tap_sel),
    .toggle (lo_tick)
  );

  cyc_tap_edge #(.W(CNT_W), .NUM(4), .SEL_W(2), .POSV(SY_POSV)) u_sy_edge (
    .cur    (cyc_count),
    .prev   (cnt_prev),
    .sel    (sync_sel),
    .toggle (sync_tick)
  );

  cyc_tap_postscaler #(.PS_W(PS_W)) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (lo_tick),
    .preset (ps_preset),
    .fire   (ps_fire),
    .ps_q   (ps_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_sample_ev <= 1'b0;
      cyc_ev       <= 1'b0;
      sync_pulse   <= 1'b0;
    end else begin
      pc_sample_ev <= ps_fire && pcs_en;
      cyc_ev       <= ps_fire && !pcs_en && cyc_ev_en;
      sync_pulse   <= sync_tick && sync_live(cnt_en, sync_sel);
    end
  end
endmodule

// File: rtl/cyc_tap_evgen_chk.sv
module cyc_tap_evgen_chk #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [1:0]       sync_sel,
  input logic             pcs_en,
  input logic [PS_W-1:0]  ps_preset,
  input logic [CNT_W-1:0] cyc_count,
  input logic             pc_sample_ev,
  input logic             cyc_ev,
  input logic             sync_pulse,
  input logic             lo_tick,
  input logic             ps_fire,
  input logic [PS_W-1:0]  ps_val
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cyc_count == $past(cyc_count) + 1'b1);

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cyc_count));

  assert_ps_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_tick && ps_val != '0) |=> ps_val == $past(ps_val) - 1'b1);

  assert_ps_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_tick && ps_val == '0) |=> ps_val == $past(ps_preset));

  assert_ps_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_tick |=> $stable(ps_val));

  assert_pcs_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_fire && pcs_en) |=> pc_sample_ev);

  assert_pcs_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_en |=> !cyc_ev);

  assert_sync_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> ($past(cnt_en) && $past(sync_sel) != 2'b00));

  assert_one_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_sample_ev && cyc_ev));

  assert_pcs_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sample_ev |=> !pc_sample_ev);

  assert_cyc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ev |=> !cyc_ev);

  assert_sync_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);
endmodule

bind cyc_tap_evgen cyc_tap_evgen_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_en       (cnt_en),
  .sync_sel     (sync_sel),
  .pcs_en       (pcs_en),
  .ps_preset    (ps_preset),
  .cyc_count    (cyc_count),
  .pc_sample_ev (pc_sample_ev),
  .cyc_ev       (cyc_ev),
  .sync_pulse   (sync_pulse),
  .lo_tick      (lo_tick),
  .ps_fire      (ps_fire),
  .ps_val       (ps_val)
);

// File: tb/cyc_tap_evgen_tb.sv
`timescale 1ns/1ps
module cyc_tap_evgen_tb;
  localparam int CNT_W = 12;
  localparam int PS_W  = 4;
  localparam int LO_A  = 2;
  localparam int LO_B  = 3;
  localparam int SY_1  = 5;
  localparam int SY_2  = 7;
  localparam int SY_3  = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cnt_en = 1'b0;
  logic             lo_tap_sel = 1'b0;
  logic [1:0]       sync_sel = 2'b00;
  logic             pcs_en = 1'b0;
  logic             cyc_ev_en = 1'b0;
  logic [PS_W-1:0]  ps_preset = '0;
  logic [CNT_W-1:0] cyc_count;
  logic             pc_sample_ev, cyc_ev, sync_pulse;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cyc_tap_evgen #(.CNT_W(CNT_W), .PS_W(PS_W), .LO_A(LO_A), .LO_B(LO_B),
                  .SY_1(SY_1), .SY_2(SY_2), .SY_3(SY_3)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .lo_tap_sel(lo_tap_sel),
    .sync_sel(sync_sel), .pcs_en(pcs_en), .cyc_ev_en(cyc_ev_en),
    .ps_preset(ps_preset), .cyc_count(cyc_count), .pc_sample_ev(pc_sample_ev),
    .cyc_ev(cyc_ev), .sync_pulse(sync_pulse)
  );

  // Reference model written from the requirements
  int unsigned m_cnt, m_prev, m_ps;
  bit e_pcs, e_cyc, e_sync;

  function automatic bit bit_moved(int unsigned a, int unsigned b, int pos);
    return (((a ^ b) >> pos) & 1) != 0;
  endfunction

  function automatic int sync_bit(logic [1:0] s);
    case (s)
      2'b01:   return SY_1;
      2'b10:   return SY_2;
      default: return SY_3;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_prev <= 0; m_ps <= 0;
      e_pcs <= 0; e_cyc <= 0; e_sync <= 0;
    end else begin
      bit tk, fz;
      tk = bit_moved(m_cnt, m_prev, lo_tap_sel ? LO_B : LO_A);
      fz = tk && (m_ps == 0);
      e_pcs  <= fz && pcs_en;
      e_cyc  <= fz && !pcs_en && cyc_ev_en;
      e_sync <= cnt_en && (sync_sel != 0) && bit_moved(m_cnt, m_prev, sync_bit(sync_sel));
      if (tk) m_ps <= (m_ps == 0) ? int'(ps_preset) : m_ps - 1;
      m_prev <= m_cnt;
      if (cnt_en) m_cnt <= (m_cnt + 1) % (1 << CNT_W);
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(cyc_count == CNT_W'(m_cnt), "R1 count", int'(cyc_count), int'(m_cnt));
      check(pc_sample_ev == e_pcs, "R3/R4/R5 pc_sample_ev", int'(pc_sample_ev), int'(e_pcs));
      check(cyc_ev == e_cyc, "R4/R6 cyc_ev", int'(cyc_ev), int'(e_cyc));
      check(sync_pulse == e_sync, "R7/R8 sync_pulse", int'(sync_pulse), int'(e_sync));
    end
  end

  int n_pcs = 0, n_cyc = 0, n_sync = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pc_sample_ev) n_pcs++;
      if (cyc_ev)       n_cyc++;
      if (sync_pulse)   n_sync++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cyc_count == '0, "R2 reset count", int'(cyc_count), 0);
    check({pc_sample_ev, cyc_ev, sync_pulse} == 3'b000, "R2 reset pulses",
          int'({pc_sample_ev, cyc_ev, sync_pulse}), 0);
    rst_n = 1'b1;
  endtask

  logic [7:0] lfsr = 8'hA5;

  initial begin
    cmp_on = 1'b1;

    // Sweep: tap select x preset x event-enable mode, some runs with gated counting
    for (int sel = 0; sel < 2; sel++) begin
      for (int pre = 0; pre < 16; pre++) begin
        for (int mode = 0; mode < 4; mode++) begin
          lo_tap_sel = sel[0];
          ps_preset  = PS_W'(pre);
          pcs_en     = mode[0];
          cyc_ev_en  = mode[1];
          sync_sel   = 2'(pre);
          do_reset();
          for (int c = 0; c < 200; c++) begin
            if (pre[0]) begin
              lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
              cnt_en = lfsr[0] | lfsr[1];
            end else begin
              cnt_en = 1'b1;
            end
            @(negedge clk);
          end
        end
      end
    end

    // R4: preset changed mid-run is used at the next reload
    lo_tap_sel = 1'b0; pcs_en = 1'b1; cyc_ev_en = 1'b1; ps_preset = 4'd3;
    do_reset(); cnt_en = 1'b1;
    repeat (150) @(negedge clk);
    ps_preset = 4'd9;
    repeat (300) @(negedge clk);

    // R4/R5: tally, preset 3 and tap LO_A. Ticks fall at counts 4,8,...
    // Fires on ticks 1,5,9,... -> counts 4,20,36,... ; pulse one cycle later.
    ps_preset = 4'd3; do_reset(); cnt_en = 1'b1; n_pcs = 0;
    repeat (16 * 10 + 5) @(negedge clk);
    check(n_pcs == 10, "R4 one event per preset+1 ticks", n_pcs, 10);

    // R6: pcs_en overrides cycle-count event
    pcs_en = 1'b1; cyc_ev_en = 1'b1; n_cyc = 0;
    repeat (400) @(negedge clk);
    check(n_cyc == 0, "R6 override", n_cyc, 0);

    // R7: sync off never pulses
    sync_sel = 2'b00; do_reset(); cnt_en = 1'b1; n_sync = 0;
    repeat (1200) @(negedge clk);
    check(n_sync == 0, "R7 sync off", n_sync, 0);

    // R7: each sync source, full tap periods
    for (int s = 1; s < 4; s++) begin
      sync_sel = 2'(s); do_reset(); cnt_en = 1'b1;
      repeat (1100) @(negedge clk);
    end

    // R8: counter stopped right after a sync tap change
    sync_sel = 2'b01; do_reset(); cnt_en = 1'b1;
    repeat (32) @(negedge clk);
    cnt_en = 1'b0; n_sync = 0;
    repeat (40) @(negedge clk);
    check(n_sync == 0, "R8 no sync with counter stopped", n_sync, 0);
    check(cyc_count == 12'd32, "R1 hold while stopped", int'(cyc_count), 32);

    // R1: wrap
    do_reset(); cnt_en = 1'b1;
    repeat ((1 << CNT_W) - 1) @(negedge clk);
    check(cyc_count == '1, "R1 all ones", int'(cyc_count), (1 << CNT_W) - 1);
    @(negedge clk);
    check(cyc_count == '0, "R1 wrap to zero", int'(cyc_count), 0);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule